// File: doc/BRIEF.md
# Burst-Readable Receive Frame Buffer Port

This block is a memory-mapped slave on a 32-bit bus. It stores received frames as a queue of 32-bit words. A host drains the queue by reading a data window. Every read beat that hits the window while at least one whole frame is stored returns the oldest stored word and removes it. The host can drain a frame with single reads, with a stationary burst that holds the address, or with an incrementing burst that steps the address by one word per beat. All offsets inside the window are aliases of the same data port, so an incrementing burst of up to 64 words pops one word per beat, the same as a stationary burst.

Each frame starts with a format word. Bits 15:11 of that word hold a count of the words that follow it in the same frame. The usual layout is identifier, timestamp low, timestamp high, then payload. The load port at its own offset appends words to the queue. A frame becomes readable only after its last word is loaded. A status register reports how many complete frames are stored and whether none are.

The bus address is decoded in fields. Bits 19:16 must equal the component-type parameter. Bits 15:12 must equal the instance parameter. All higher bits and bits 1:0 must be zero. Bits 11:0 select the offset: status at 0x004, load at 0x008, and the data window at 0x100 to 0x1FC by default.

Top module: `rxbuf_burst_port`

## Requirements
- R1: A beat whose component-type field (bits 19:16) or instance field (bits 15:12) does not match the parameters, or whose upper or lowest two address bits are not zero, returns 0 on a read and changes no state.
- R2: A read beat in the data window, while at least one complete frame is stored, returns the oldest stored word on `rdata` during that beat and removes exactly that one word at the clock edge.
- R3: Every word offset from RXWIN_BASE up to RXWIN_BASE + 4*(RXWIN_WORDS-1) reaches the same data port. A stationary burst and an incrementing burst therefore return identical word sequences.
- R4: Read beats at any offset outside the data window never remove a word.
- R5: A read in the data window while no complete frame is stored returns 0 and leaves the queue unchanged.
- R6: Words leave the queue in the order they were loaded. A frame is counted complete once its format word and the number of further words given in format-word bits 15:11 are loaded. Words of an incomplete frame are not readable.
- R7: A read at the status offset returns the complete-frame count in bits 15:0 and an empty flag in bit 16 (1 when the count is 0). All other bits are 0.
- R8: A write beat at the load offset appends `wdata` only when all four byte enables are set. A write with any byte enable cleared is ignored.
- R9: A load beat while DEPTH words are stored is ignored, and the word count never exceeds DEPTH.
- R10: After reset the queue is empty and the status register reads 0x0001_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select; a beat occurs when high with rd or wr |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| be | input | 4 | Byte enables |
| addr | input | ADDR_W | Byte address of the beat |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid during the read beat |

## Verification
The bound checker watches every cycle for several properties. A read with no complete frame must not change the word count and must return zero. A read beat outside the window must never shrink the queue. A read in the window with a frame available must shrink it by exactly one word. The word count must stay within DEPTH, and complete frames can never outnumber stored words. Some behaviour only shows at the ports, and the bench scenarios cover it. They check word order across frame boundaries, stationary versus incrementing bursts, frames becoming visible only when their last word is loaded, byte-enable and address-field rejection, and overflow when loading past capacity.

// File: rtl/rxbp_pkg.sv
package rxbp_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned FOLLOW_LSB = 11;
  localparam int unsigned FOLLOW_W  = 5;
  localparam int unsigned EMPTY_BIT = 16;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_WINDOW = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_LOAD   = 2'd3
  } bus_sel_e;

  function automatic logic [FOLLOW_W-1:0] follow_count(input logic [WORD_W-1:0] w);
    return w[FOLLOW_LSB +: FOLLOW_W];
  endfunction

endpackage

// File: rtl/rxbp_decode.sv
module rxbp_decode
  import rxbp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter logic [3:0]  COMP_TYPE   = 4'h1,
  parameter logic [3:0]  INST_ID     = 4'h0,
  parameter int unsigned RXWIN_BASE  = 12'h100,
  parameter int unsigned RXWIN_WORDS = 64,
  parameter int unsigned STATUS_OFS  = 12'h004,
  parameter int unsigned LOAD_OFS    = 12'h008
) (
  input  logic [ADDR_W-1:0] addr,
  output bus_sel_e          sel
);

  localparam logic [10:0] WIN_LO  = 11'(RXWIN_BASE / 4);
  localparam logic [10:0] WIN_HI  = 11'(RXWIN_BASE / 4 + RXWIN_WORDS);
  localparam logic [9:0]  STAT_WI = 10'(STATUS_OFS / 4);
  localparam logic [9:0]  LOAD_WI = 10'(LOAD_OFS / 4);

  logic       field_ok;
  logic [9:0] word_idx;

  always_comb begin
    field_ok = (addr[19:16] == COMP_TYPE) && (addr[15:12] == INST_ID) &&
               (addr[1:0] == 2'b00) && (addr[ADDR_W-1:20] == '0);
    word_idx = addr[11:2];
    sel      = SEL_NONE;
    if (field_ok) begin
      if (({1'b0, word_idx} >= WIN_LO) && ({1'b0, word_idx} < WIN_HI)) begin
        sel = SEL_WINDOW;
      end else if (word_idx == STAT_WI) begin
        sel = SEL_STATUS;
      end else if (word_idx == LOAD_WI) begin
        sel = SEL_LOAD;
      end
    end
  end

endmodule

// File: rtl/rxbp_word_fifo.sv
module rxbp_word_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [DATA_W-1:0]         push_data,
  input  logic                      pop,
  output logic [DATA_W-1:0]         head,
  output logic [$clog2(DEPTH):0]    count,
  output logic                      full
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, wr_ptr_d;
  logic [AW-1:0]     rd_ptr, rd_ptr_d;
  logic [CW-1:0]     cnt_d;

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    cnt_d    = count;
    if (push) begin
      wr_ptr_d = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    end
    if (pop) begin
      rd_ptr_d = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end
    case ({push, pop})
      2'b10:   cnt_d = count + 1'b1;
      2'b01:   cnt_d = count - 1'b1;
      default: cnt_d = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr] <= push_data;
    end
  end

  assign head = mem[rd_ptr];
  assign full = (count == CW'(DEPTH));

endmodule

// File: rtl/rxbp_frame_track.sv
module rxbp_frame_track
  import rxbp_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [FOLLOW_W-1:0]     push_follow,
  input  logic                    pop,
  input  logic [FOLLOW_W-1:0]     head_follow,
  output logic [$clog2(DEPTH):0]  frame_cnt
);

  localparam int unsigned CW = $clog2(DEPTH) + 1;

  logic [FOLLOW_W-1:0] wr_rem, wr_rem_d;
  logic [FOLLOW_W-1:0] rd_rem, rd_rem_d;
  logic [CW-1:0]       fcnt_d;
  logic                commit, retire;

  always_comb begin
    wr_rem_d = wr_rem;
    commit   = 1'b0;
    if (push) begin
      if (wr_rem == '0) begin
        wr_rem_d = push_follow;
        commit   = (push_follow == '0);
      end else begin
        wr_rem_d = wr_rem - 1'b1;
        commit   = (wr_rem == FOLLOW_W'(1));
      end
    end
  end

  always_comb begin
    rd_rem_d = rd_rem;
    retire   = 1'b0;
    if (pop) begin
      if (rd_rem == '0) begin
        rd_rem_d = head_follow;
        retire   = (head_follow == '0);
      end else begin
        rd_rem_d = rd_rem - 1'b1;
        retire   = (rd_rem == FOLLOW_W'(1));
      end
    end
  end

  always_comb begin
    case ({commit, retire})
      2'b10:   fcnt_d = frame_cnt + 1'b1;
      2'b01:   fcnt_d = frame_cnt - 1'b1;
      default: fcnt_d = frame_cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_rem    <= '0;
      rd_rem    <= '0;
      frame_cnt <= '0;
    end else begin
      wr_rem    <= wr_rem_d;
      rd_rem    <= rd_rem_d;
      frame_cnt <= fcnt_d;
    end
  end

endmodule

// File: rtl/rxbuf_burst_port.sv
module rxbuf_burst_port
  import rxbp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter logic [3:0]  COMP_TYPE   = 4'h1,
  parameter logic [3:0]  INST_ID     = 4'h0,
  parameter int unsigned DEPTH       = 64,
  parameter int unsigned RXWIN_BASE  = 12'h100,
  parameter int unsigned RXWIN_WORDS = 64,
  parameter int unsigned STATUS_OFS  = 12'h004,
  parameter int unsigned LOAD_OFS    = 12'h008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [3:0]        be,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);

  localparam int unsigned CW = $clog2(DEPTH) + 1;

  bus_sel_e          sel;
  logic              rd_beat, wr_beat;
  logic              push, pop, full, have_frame;
  logic [31:0]       head;
  logic [CW-1:0]     fifo_cnt;
  logic [CW-1:0]     frame_cnt;
  logic [31:0]       status_word;

  rxbp_decode #(
    .ADDR_W(ADDR_W), .COMP_TYPE(COMP_TYPE), .INST_ID(INST_ID),
    .RXWIN_BASE(RXWIN_BASE), .RXWIN_WORDS(RXWIN_WORDS),
    .STATUS_OFS(STATUS_OFS), .LOAD_OFS(LOAD_OFS)
  ) u_decode (
    .addr (addr),
    .sel  (sel)
  );

  assign rd_beat    = cs && rd;
  assign wr_beat    = cs && wr;
  assign have_frame = (frame_cnt != '0);
  assign pop        = rd_beat && (sel == SEL_WINDOW) && have_frame;
  assign push       = wr_beat && (sel == SEL_LOAD) && (be == 4'hF) && !full;

  rxbp_word_fifo #(
    .DATA_W(WORD_W), .DEPTH(DEPTH)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (wdata),
    .pop       (pop),
    .head      (head),
    .count     (fifo_cnt),
    .full      (full)
  );

  rxbp_frame_track #(
    .DEPTH(DEPTH)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (push),
    .push_follow (follow_count(wdata)),
    .pop         (pop),
    .head_follow (follow_count(head)),
    .frame_cnt   (frame_cnt)
  );

  always_comb begin
    status_word                = '0;
    status_word[15:0]          = 16'(frame_cnt);
    status_word[EMPTY_BIT]     = !have_frame;
  end

  always_comb begin
    rdata = '0;
    if (rd_beat) begin
      case (sel)
        SEL_WINDOW: rdata = have_frame ? head : '0;
        SEL_STATUS: rdata = status_word;
        default:    rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/rxbp_checker.sv
module rxbp_checker #(
  parameter int unsigned ADDR_W      = 24,
  parameter logic [3:0]  COMP_TYPE   = 4'h1,
  parameter logic [3:0]  INST_ID     = 4'h0,
  parameter int unsigned DEPTH       = 64,
  parameter int unsigned RXWIN_BASE  = 12'h100,
  parameter int unsigned RXWIN_WORDS = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cs,
  input logic                    rd,
  input logic                    wr,
  input logic [ADDR_W-1:0]       addr,
  input logic [31:0]             rdata,
  input logic [$clog2(DEPTH):0]  word_cnt,
  input logic [$clog2(DEPTH):0]  frame_cnt
);

  localparam int unsigned CW = $clog2(DEPTH) + 1;
  localparam int unsigned LO = RXWIN_BASE / 4;
  localparam int unsigned HI = RXWIN_BASE / 4 + RXWIN_WORDS;

  logic in_win, win_rd, any_wr;
  int unsigned widx;

  always_comb begin
    widx   = int'(addr[11:2]);
    in_win = (addr[ADDR_W-1:20] == '0) && (addr[19:16] == COMP_TYPE) &&
             (addr[15:12] == INST_ID) && (addr[1:0] == 2'b00) &&
             (widx >= LO) && (widx < HI);
    win_rd = cs && rd && in_win;
    any_wr = cs && wr;
  end

  AST_EMPTY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && frame_cnt == '0 && !any_wr) |=> $stable(word_cnt)); // R5
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && frame_cnt == '0) |-> (rdata == '0)); // R5
  AST_OUTSIDE_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_rd && !any_wr) |=> $stable(word_cnt)); // R4
  AST_POP_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && frame_cnt != '0 && !any_wr) |=> (word_cnt == $past(word_cnt) - CW'(1))); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    word_cnt <= CW'(DEPTH)); // R9
  AST_FRAMES_WITHIN_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt <= word_cnt); // R6

endmodule

bind rxbuf_burst_port rxbp_checker #(
  .ADDR_W(ADDR_W), .COMP_TYPE(COMP_TYPE), .INST_ID(INST_ID), .DEPTH(DEPTH),
  .RXWIN_BASE(RXWIN_BASE), .RXWIN_WORDS(RXWIN_WORDS)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs        (cs),
  .rd        (rd),
  .wr        (wr),
  .addr      (addr),
  .rdata     (rdata),
  .word_cnt  (fifo_cnt),
  .frame_cnt (frame_cnt)
);

// File: tb/rxbuf_burst_port_test.sv
module rxbuf_burst_port_test;

  localparam int unsigned ADDR_W = 24;
  localparam logic [3:0]  COMP   = 4'h1;
  localparam logic [3:0]  INST   = 4'h3;
  localparam int unsigned DEPTH  = 16;

  logic              clk, rst_n, cs, rd, wr;
  logic [3:0]        be;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wdata, rdata;

  int unsigned total, fails;
  bit          done;

  logic [31:0] model_q[$];
  logic [31:0] exp_q[$];
  logic [31:0] obs_q[$];
  string       tag_q[$];

  rxbuf_burst_port #(
    .ADDR_W(ADDR_W), .COMP_TYPE(COMP), .INST_ID(INST), .DEPTH(DEPTH)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .be(be),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [ADDR_W-1:0] mk(input logic [3:0] c, input logic [3:0] i,
                                           input logic [11:0] ofs);
    return {4'h0, c, i, ofs};
  endfunction

  function automatic logic [31:0] fmt(input int follow, input int low);
    return (32'(follow) << 11) | (32'(low) & 32'h7FF) | 32'h5000_0000;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                           input logic [3:0] b, input bit accepted);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; rd = 1'b0; be = b; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    cs = 1'b0; wr = 1'b0; be = '0;
    if (accepted) model_q.push_back(d);
  endtask

  // Driver: each beat queues its expected word, the monitor compares.
  task automatic burst_read(input logic [ADDR_W-1:0] a, input int beats, input bit stat,
                            input int n_model, input string tag);
    logic [ADDR_W-1:0] cur;
    cur = a;
    @(negedge clk);
    for (int i = 0; i < beats; i++) begin
      cs = 1'b1; rd = 1'b1; wr = 1'b0; be = 4'hF; addr = cur;
      if (i < n_model) exp_q.push_back(model_q.pop_front());
      else exp_q.push_back(32'h0);
      #5;
      obs_q.push_back(rdata);
      tag_q.push_back(tag);
      @(posedge clk);
      if (!stat) cur = cur + 4;
      @(negedge clk);
    end
    cs = 1'b0; rd = 1'b0; be = '0;
  endtask

  task automatic status_is(input logic [31:0] exp, input string tag);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; wr = 1'b0; addr = mk(COMP, INST, 12'h004);
    #5;
    check(rdata == exp, tag, rdata, exp);
    @(posedge clk);
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk);
      while (obs_q.size() > 0) begin
        logic [31:0] o, e;
        string t;
        o = obs_q.pop_front();
        t = tag_q.pop_front();
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEAD_BEEF;
        check(o == e, t, o, e);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual hang expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] win, ld;
    total = 0; fails = 0; done = 0;
    cs = 0; rd = 0; wr = 0; be = 0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    win = mk(COMP, INST, 12'h100);
    ld  = mk(COMP, INST, 12'h008);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    status_is(32'h0001_0000, "R10 reset status");
    burst_read(win, 1, 1, 0, "R5 empty after reset");

    // Frame A: header only; visible only after its last word (R6)
    bus_write(ld, fmt(3, 8'h00), 4'hF, 1);
    bus_write(ld, 32'h1ABC_0001, 4'hF, 1);
    bus_write(ld, 32'hAAAA_0010, 4'hF, 1);
    status_is(32'h0001_0000, "R6 partial frame hidden");
    bus_write(ld, 32'hAAAA_0011, 4'hF, 1);
    status_is(32'h0000_0001, "R6 R7 one frame");

    // Frame B with two payload words
    bus_write(ld, fmt(5, 8'h02), 4'hF, 1);
    bus_write(ld, 32'h0000_07FF, 4'hF, 1);
    bus_write(ld, 32'hBBBB_0020, 4'hF, 1);
    bus_write(ld, 32'hBBBB_0021, 4'hF, 1);
    bus_write(ld, 32'hC0DE_0001, 4'hF, 1);
    bus_write(ld, 32'hC0DE_0002, 4'hF, 1);
    status_is(32'h0000_0002, "R7 two frames");

    burst_read(win, 4, 1, 4, "R2 R3 stationary burst");
    status_is(32'h0000_0001, "R2 one frame left");

    burst_read(mk(COMP, INST, 12'h010), 2, 1, 0, "R4 other offset reads zero");
    status_is(32'h0000_0001, "R4 no pop elsewhere");
    burst_read(win, 6, 0, 6, "R3 incrementing burst");
    status_is(32'h0001_0000, "R6 drained");
    burst_read(mk(COMP, INST, 12'h1FC), 2, 0, 0, "R5 empty window read");
    status_is(32'h0001_0000, "R5 still empty");

    // Address field rejection (R1)
    bus_write(mk(COMP, 4'h2, 12'h008), fmt(0, 1), 4'hF, 0);
    bus_write(mk(4'h7, INST, 12'h008), fmt(0, 2), 4'hF, 0);
    status_is(32'h0001_0000, "R1 foreign write ignored");

    // Byte enables (R8)
    bus_write(ld, fmt(0, 3), 4'h7, 0);
    status_is(32'h0001_0000, "R8 partial enables ignored");
    bus_write(ld, fmt(0, 4), 4'hF, 1);
    status_is(32'h0000_0001, "R8 full enables load");
    burst_read(mk(COMP, 4'h0, 12'h100), 1, 1, 0, "R1 foreign read zero");
    burst_read(mk(4'h1, INST, 12'h102), 1, 1, 0, "R1 unaligned read zero");
    status_is(32'h0000_0001, "R1 no pop on foreign read");
    burst_read(win, 1, 1, 1, "R2 single read");

    // Overflow (R9)
    for (int i = 0; i < DEPTH + 1; i++) begin
      bus_write(ld, fmt(0, 16 + i), 4'hF, (i < DEPTH));
    end
    status_is(32'h0000_0010, "R9 full count");
    burst_read(win, DEPTH + 1, 1, DEPTH, "R9 overflow word dropped");
    status_is(32'h0001_0000, "R9 empty after drain");

    repeat (4) @(posedge clk);
    check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule